// File: doc/BRIEF.md
# Zero-Cross Digital Volume Control

This block scales one stereo path of signed 24-bit PCM samples by a per-channel gain, set in half-decibel steps by an 8-bit attenuation code. Samples arrive one at a time with a valid strobe and a channel bit. The scaled sample leaves two clock cycles later with the same channel bit.

Software loads new codes for both channels on the attenuation inputs and pulses an update request. When zero-cross mode is off, each channel takes its new code on its next sample. When zero-cross mode is on, each channel holds its new code as pending. The channel applies that code only on a sample that is zero or has the opposite sign to the channel's previous sample. This hides the gain step inside a signal crossing and so avoids audible clicks. A sample counter per channel forces the pending code in after a fixed number of samples, so a silent or DC-offset channel still picks up the change.

Top module: `zcv_volume_top`

## Requirements
- R1: While reset is high and after it is released, out_valid is 0 and out_sample is 0. Both channels start at code 0xFF (unity gain), so the first samples pass through unchanged.
- R2: For code c, let a = 255 - c, q = a / 12 and r = a mod 12. The gain word is G = floor(round(32768 * 10^(-r/40)) / 2^q). Code 0 gives G = 0 (mute). Each 12 steps therefore halve the gain exactly.
- R3: For an input sample s, out_sample = floor((s*G + 16384) / 32768), clipped to the 24-bit signed range. It appears with out_valid = 1 and the input's channel bit, two clock edges after the input edge.
- R4: Samples with in_chan = 0 (left) use the left attenuation code. Samples with in_chan = 1 (right) use the right code.
- R5: An upd_req pulse captures both attenuation inputs. With zc_en = 0, the next sample of each channel, and every later one, uses the captured code.
- R6: With zc_en = 1, a channel keeps its old gain until it receives a sample that is zero or whose sign differs from that channel's previous sample. That sample and all later samples use the new code.
- R7: Left and right each hold their own pending code and commit it on their own crossing, independently of the other channel.
- R8: With zc_en = 1 and no crossing, a pending code is applied on the 1024th sample of that channel after the request.
- R9: Changing the attenuation inputs without an upd_req pulse has no effect on the output.
- R10: A new upd_req while a code is pending replaces the pending code and restarts the 1024-sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 1 | Input channel, 0 left, 1 right |
| in_sample | input | 24 | Signed input sample |
| atten_l | input | 8 | Left attenuation code |
| atten_r | input | 8 | Right attenuation code |
| zc_en | input | 1 | Defer gain changes to zero crossings |
| upd_req | input | 1 | One-cycle pulse that captures both codes |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Channel of the output sample |
| out_sample | output | 24 | Scaled, rounded, saturated sample |

## Verification
The gain path is tried with codes that fall on exact powers of two (0xFF, 0xF3), with fractional steps (0xFE, 0x80, 0x01) and with mute. These are combined with full-scale positive, full-scale negative and mid-range samples, which separates table errors from rounding and sign errors.

Zero-cross behaviour is driven with a steady positive stream, then with a sign flip on one channel and an exact zero on the other. This shows whether a commit waits, fires on the right sample and stays confined to its channel.

Long crossing-free runs of exactly 1023 and 1024 samples pin the timeout to the right sample. A request issued mid-run shows whether the pending code is replaced and the count is restarted.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
    localparam int DATA_W = 24;
    localparam int CODE_W = 8;
    localparam int GAIN_W = 16;
    localparam int FRAC_W = 15;
    localparam int STEPS_PER_HALVING = 12;
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam logic [CODE_W-1:0] CODE_UNITY = '1;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic [CODE_W-1:0]        code_t;
    typedef logic [GAIN_W-1:0]        gain_t;

    typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;

    typedef struct packed {
        logic    valid;
        chan_e   chan;
        sample_t sample;
        gain_t   gain;
    } scale_req_t;

    // Mantissa for one octave of half-dB steps: round(32768 * 10^(-r/40))
    function automatic gain_t octave_base(input int unsigned r);
        case (r)
            0:       return gain_t'(32768);
            1:       return gain_t'(30935);
            2:       return gain_t'(29205);
            3:       return gain_t'(27571);
            4:       return gain_t'(26029);
            5:       return gain_t'(24573);
            6:       return gain_t'(23198);
            7:       return gain_t'(21900);
            8:       return gain_t'(20675);
            9:       return gain_t'(19519);
            10:      return gain_t'(18427);
            default: return gain_t'(17396);
        endcase
    endfunction

    function automatic logic [DATA_W:0] magnitude(input sample_t s);
        logic signed [DATA_W:0] w;
        w = {s[DATA_W-1], s};
        return w[DATA_W] ? logic'(1'b0) + (-w) : w;
    endfunction
endpackage

// File: rtl/zcv_gain_lut.sv
module zcv_gain_lut
    import zcv_pkg::*;
(
    input  code_t code,
    output gain_t gain
);
    localparam int FULL_CODE = (1 << CODE_W) - 1;

    int unsigned atten_steps;
    int unsigned shift_amt;
    int unsigned frac_step;
    gain_t       mantissa;

    always_comb begin
        atten_steps = FULL_CODE - int'(code);
        shift_amt   = atten_steps / STEPS_PER_HALVING;
        frac_step   = atten_steps % STEPS_PER_HALVING;
        mantissa    = octave_base(frac_step);
        if (code == '0) begin
            gain = '0;
        end else if (shift_amt >= GAIN_W) begin
            gain = '0;
        end else begin
            gain = mantissa >> shift_amt;
        end
    end
endmodule

// File: rtl/zcv_tracker.sv
module zcv_tracker
    import zcv_pkg::*;
#(
    parameter int TIMEOUT_SAMPLES = 1024
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    smp_valid,
    input  sample_t smp_value,
    input  logic    zc_en,
    input  logic    upd_req,
    input  code_t   new_code,
    output code_t   eff_code
);
    localparam int CNT_W = $clog2(TIMEOUT_SAMPLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_SAMPLES - 1);

    code_t            act_code_q;
    code_t            pend_code_q;
    logic             pend_q;
    logic [CNT_W-1:0] wait_cnt_q;
    logic             prev_neg_q;

    logic crossing;
    logic expired;
    logic commit;

    assign crossing = (smp_value == '0) || (smp_value[DATA_W-1] != prev_neg_q);
    assign expired  = (wait_cnt_q == CNT_LAST);
    assign commit   = smp_valid && pend_q && (!zc_en || crossing || expired);
    assign eff_code = commit ? pend_code_q : act_code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_code_q  <= CODE_UNITY;
            pend_code_q <= CODE_UNITY;
            pend_q      <= 1'b0;
            wait_cnt_q  <= '0;
            prev_neg_q  <= 1'b0;
        end else begin
            if (smp_valid) begin
                prev_neg_q <= smp_value[DATA_W-1];
            end
            if (commit) begin
                act_code_q <= pend_code_q;
            end
            if (upd_req) begin
                pend_q      <= 1'b1;
                pend_code_q <= new_code;
                wait_cnt_q  <= '0;
            end else if (commit) begin
                pend_q     <= 1'b0;
                wait_cnt_q <= '0;
            end else if (smp_valid && pend_q) begin
                wait_cnt_q <= wait_cnt_q + 1'b1;
            end
        end
    end

    // R6
    commit_clears_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !upd_req) |=> !pend_q);

    // R8
    timeout_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> (wait_cnt_q <= CNT_LAST));

    // R9
    idle_code_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !upd_req) |=> $stable(act_code_q));
endmodule

// File: rtl/zcv_scaler.sv
module zcv_scaler
    import zcv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  scale_req_t req,
    output logic       out_valid,
    output logic       out_chan,
    output sample_t    out_sample
);
    localparam logic signed [PROD_W-1:0] ROUND_HALF = PROD_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [PROD_W-1:0] SAT_MAX    = PROD_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_MIN    = -(PROD_W'(1) <<< (DATA_W - 1));

    logic signed [PROD_W-1:0] product;
    logic signed [PROD_W-1:0] rounded;
    sample_t                  clipped;

    always_comb begin
        product = PROD_W'(req.sample) * $signed({1'b0, req.gain});
        rounded = (product + ROUND_HALF) >>> FRAC_W;
        if (rounded > SAT_MAX) begin
            clipped = SAT_MAX[DATA_W-1:0];
        end else if (rounded < SAT_MIN) begin
            clipped = SAT_MIN[DATA_W-1:0];
        end else begin
            clipped = rounded[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_chan   <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid  <= req.valid;
            out_chan   <= req.chan;
            out_sample <= req.valid ? clipped : out_sample;
        end
    end

    // R2
    mute_gives_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.gain == '0) |=> (out_sample == '0));

    // R3
    no_gain_above_unity_chk: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> (magnitude(out_sample) <= magnitude($past(req.sample)) + 1));
endmodule

// File: rtl/zcv_volume_top.sv
module zcv_volume_top
    import zcv_pkg::*;
#(
    parameter int TIMEOUT_SAMPLES = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_chan,
    input  logic signed [23:0]       in_sample,
    input  logic [7:0]               atten_l,
    input  logic [7:0]               atten_r,
    input  logic                     zc_en,
    input  logic                     upd_req,
    output logic                     out_valid,
    output logic                     out_chan,
    output logic signed [23:0]       out_sample
);
    localparam int NUM_CH = 2;

    code_t      ch_code_in [NUM_CH];
    code_t      ch_eff     [NUM_CH];
    code_t      sel_code;
    gain_t      sel_gain;
    scale_req_t stage_d;
    scale_req_t stage_q;

    assign ch_code_in[0] = atten_l;
    assign ch_code_in[1] = atten_r;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic ch_hit;
        assign ch_hit = in_valid && (in_chan == ch[0]);
        zcv_tracker #(.TIMEOUT_SAMPLES(TIMEOUT_SAMPLES)) u_trk (
            .clk       (clk),
            .rst       (rst),
            .smp_valid (ch_hit),
            .smp_value (in_sample),
            .zc_en     (zc_en),
            .upd_req   (upd_req),
            .new_code  (ch_code_in[ch]),
            .eff_code  (ch_eff[ch])
        );
    end

    assign sel_code = in_chan ? ch_eff[1] : ch_eff[0];

    zcv_gain_lut u_lut (
        .code (sel_code),
        .gain (sel_gain)
    );

    always_comb begin
        stage_d.valid  = in_valid;
        stage_d.chan   = chan_e'(in_chan);
        stage_d.sample = in_sample;
        stage_d.gain   = sel_gain;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    zcv_scaler u_scl (
        .clk        (clk),
        .rst        (rst),
        .req        (stage_q),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_sample (out_sample)
    );

    // R3
    two_stage_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(stage_q.valid));

    // R4
    chan_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        stage_q.valid |=> (out_chan == $past(stage_q.chan)));
endmodule

// File: tb/tb_zcv_volume_top.sv
module tb_zcv_volume_top;
    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_chan, zc_en, upd_req;
    logic signed [23:0] in_sample;
    logic [7:0] atten_l, atten_r;
    logic out_valid, out_chan;
    logic signed [23:0] out_sample;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int act_l, act_r;

    always #10 clk = ~clk;

    zcv_volume_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .atten_l(atten_l), .atten_r(atten_r),
        .zc_en(zc_en), .upd_req(upd_req), .out_valid(out_valid),
        .out_chan(out_chan), .out_sample(out_sample)
    );

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint exp_gain(int code);
        int a, q, r;
        real b;
        if (code == 0) return 0;
        a = 255 - code;
        q = a / 12;
        r = a % 12;
        b = $floor(32768.0 * $pow(10.0, -r / 40.0) + 0.5);
        if (q >= 63) return 0;
        return longint'(b) >>> q;
    endfunction

    task automatic send(bit ch, int s, int code, string tag);
        longint e;
        @(negedge clk);
        in_valid = 1'b1; in_chan = ch; in_sample = s[23:0];
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        e = (longint'(s) * exp_gain(code) + 16384) >>> 15;
        if (e > 8388607) e = 8388607;
        if (e < -8388608) e = -8388608;
        check({tag, " out_valid"}, longint'(out_valid), 1);
        check({tag, " out_chan"}, longint'(out_chan), longint'(ch));
        check(tag, longint'(out_sample), e);
    endtask

    task automatic request(int l, int r);
        @(negedge clk);
        atten_l = l[7:0]; atten_r = r[7:0]; upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 0; in_chan = 0; in_sample = '0;
        atten_l = 8'hFF; atten_r = 8'hFF; zc_en = 0; upd_req = 0;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", longint'(out_valid), 0);
        check("R1 out_sample in reset", longint'(out_sample), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", longint'(out_valid), 0);
        act_l = 255; act_r = 255;
        send(0, 1234567, 255, "R1 unity left");
        send(1, -7654321, 255, "R1 unity right");
    endtask

    task automatic t_gain_sweep();
        int codes[6] = '{255, 243, 254, 128, 1, 0};
        int smps[4] = '{8388607, -8388608, 1000001, -3};
        zc_en = 0;
        foreach (codes[i]) begin
            request(codes[i], 255 - i);
            act_l = codes[i]; act_r = 255 - i;
            foreach (smps[k]) begin
                send(0, smps[k], act_l, "R2 R3 R5 left gain");
                send(1, smps[k], act_r, "R4 R5 right gain");
            end
        end
    endtask

    task automatic t_no_update();
        zc_en = 0;
        request(200, 100);
        act_l = 200; act_r = 100;
        @(negedge clk); atten_l = 8'h10; atten_r = 8'hF0;
        send(0, 5000000, act_l, "R9 left ignores code");
        send(1, 5000000, act_r, "R9 right ignores code");
    endtask

    task automatic t_zc_commit();
        zc_en = 0;
        request(255, 255); act_l = 255; act_r = 255;
        send(0, 400000, act_l, "R6 prime left");
        send(1, 400000, act_r, "R6 prime right");
        zc_en = 1;
        request(231, 207);
        send(0, 300000, act_l, "R6 left held");
        send(1, 300000, act_r, "R7 right held");
        send(0, -300000, 231, "R6 left sign change commits"); act_l = 231;
        send(1, 250000, act_r, "R7 right still held");
        send(0, 300000, act_l, "R7 left stays new");
        send(1, 0, 207, "R6 right zero commits"); act_r = 207;
        send(1, 600000, act_r, "R7 right new");
    endtask

    task automatic t_timeout();
        zc_en = 1;
        send(0, 700000, act_l, "R8 prime");
        request(150, act_r);
        for (int i = 1; i < 1024; i++) send(0, 700000, act_l, "R8 before timeout");
        send(0, 700000, 150, "R8 timeout sample"); act_l = 150;
        send(0, 700000, act_l, "R8 after timeout");
    endtask

    task automatic t_replace();
        zc_en = 1;
        send(0, 900000, act_l, "R10 prime");
        request(60, act_r);
        for (int i = 0; i < 5; i++) send(0, 900000, act_l, "R10 first pending");
        request(90, act_r);
        for (int i = 1; i < 1024; i++) send(0, 900000, act_l, "R10 restarted count");
        send(0, 900000, 90, "R10 replaced code applied"); act_l = 90;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_gain_sweep();
        t_no_update();
        t_zc_commit();
        t_timeout();
        t_replace();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule